// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the host-facing programming interface of an eight-input interrupt controller. Software reaches it through a byte port with two addresses, selected by one address line. A byte written to the even address that has bit 4 set always restarts initialization. Every other byte is interpreted according to where the initialization sequence currently stands. The sequence takes two, three or four bytes, depending on flags carried in its first byte.

Once initialization is complete, the odd address loads the interrupt mask. The even address then carries two kinds of operation commands. The first is an end-of-interrupt or rotation command, which is handed on to the priority logic as a one-cycle strobe with its fields. The second is a read-select command, which chooses whether even-address reads return the pending-request or the in-service byte.

Request latching and priority resolution sit outside this block. They supply the request and in-service bytes as inputs and consume the exported configuration.

Top module: `picmd_seq`

## Requirements
- R1: After reset the machine waits for the first initialization byte (`ready_o`=0), every exported configuration field and the mask are 0, and even-address reads return `irr_i` (read select reset to binary 10).
- R2: An even-address write with bit 4 set, in any state, stores bit 0 (fourth byte follows), bit 1 (`single_o`), bit 2 (`adi_o`) and bit 3 (`level_o`), and moves to the state expecting the second byte, so `ready_o` is 0.
- R3: An odd-address write in the second-byte state loads `vec_base_o`. The next state is the third-byte state when bit 1 of the first byte is 0. Otherwise it is the fourth-byte state when bit 0 is 1, and ready when bit 0 is 0.
- R4: An odd-address write in the third-byte state loads `cascade_o`. The next state is the fourth-byte state when bit 0 of the first byte is 1, otherwise ready.
- R5: An odd-address write in the fourth-byte state stores bit 1 (`aeoi_o`), bit 2 (`ms_o`), bit 3 (`buf_o`) and bit 4 (`sfnm_o`), and always moves to ready. These fields change no behaviour of this block.
- R6: In ready, an odd-address write loads the mask. An odd-address read returns the mask on `rdata_o` in the cycle after the read strobe.
- R7: In ready, an even-address write with bits 4:3 = 00 is an operation command. `ocw2_stb_o` pulses for one cycle, and the command fields are held: bit 7 `ocw2_rot_o`, bit 6 `ocw2_sl_o`, bit 5 `ocw2_eoi_o`, bits 2:0 `ocw2_lvl_o`.
- R8: In ready, an even-address write with bits 4:3 = 01 stores its bits 1:0 as the read select. Even-address reads return `irr_i` for 10, `isr_i` for 11 and 0x00 for 00 or 01.
- R9: An odd-address write while waiting for the first byte, or an even-address write with bit 4 clear outside ready, changes no state and pulses `err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| rd_en_i | input | 1 | Read strobe |
| a0_i | input | 1 | Address select: 0 even, 1 odd |
| wdata_i | input | 8 | Write byte |
| irr_i | input | 8 | Pending-request byte from the request logic |
| isr_i | input | 8 | In-service byte from the priority logic |
| rdata_o | output | 8 | Read byte, registered |
| ready_o | output | 1 | Initialization complete |
| vec_base_o | output | 8 | Vector base |
| single_o | output | 1 | Single controller (no cascade) |
| adi_o | output | 1 | Address interval flag |
| level_o | output | 1 | Level-triggered request mode |
| cascade_o | output | 8 | Cascade byte |
| aeoi_o | output | 1 | Automatic end-of-interrupt flag |
| ms_o | output | 1 | Buffered master/slave select |
| buf_o | output | 1 | Buffered mode flag |
| sfnm_o | output | 1 | Special fully nested flag |
| ocw2_stb_o | output | 1 | One-cycle operation command strobe |
| ocw2_rot_o | output | 1 | Rotate field of last command |
| ocw2_sl_o | output | 1 | Specific-level field of last command |
| ocw2_eoi_o | output | 1 | End-of-interrupt field of last command |
| ocw2_lvl_o | output | 3 | Level field of last command |
| err_o | output | 1 | One-cycle pulse on an ignored write |

## Verification
Every result is due one cycle after its stimulus. Writes change the held configuration, `ready_o` and the two pulses at the clock edge that samples the strobe. A read strobe loads `rdata_o` at the same edge. The bench drives inputs on the falling edge and samples at the next falling edge. This puts every check half a cycle after the edge that produced the result. It also checks that each pulse has dropped one more cycle later.

// File: rtl/picmd_pkg.sv
package picmd_pkg;
  typedef enum logic [2:0] {ST_ICW1, ST_ICW2, ST_ICW3, ST_ICW4, ST_RDY} init_st_e;

  localparam int CW_SEL_BIT  = 4;  // 1: start of initialization
  localparam int CW_KIND_BIT = 3;  // in ready: 0 command, 1 read select

  typedef struct packed {
    logic icw1;
    logic icw2;
    logic icw3;
    logic icw4;
    logic imr;
    logic ocw2;
    logic ocw3;
    logic bad;
  } cw_ld_t;
endpackage

// File: rtl/picmd_decode.sv
module picmd_decode
  import picmd_pkg::*;
(
  input  logic     wr_en_i,
  input  logic     a0_i,
  input  logic     sel_i,
  input  logic     kind_i,
  input  init_st_e state_i,
  output cw_ld_t   ld_o
);
  always_comb begin
    ld_o = '0;
    if (wr_en_i) begin
      if (!a0_i) begin
        if (sel_i)                 ld_o.icw1 = 1'b1;
        else if (state_i == ST_RDY) begin
          if (kind_i)              ld_o.ocw3 = 1'b1;
          else                     ld_o.ocw2 = 1'b1;
        end else                   ld_o.bad  = 1'b1;
      end else begin
        unique case (state_i)
          ST_ICW2: ld_o.icw2 = 1'b1;
          ST_ICW3: ld_o.icw3 = 1'b1;
          ST_ICW4: ld_o.icw4 = 1'b1;
          ST_RDY:  ld_o.imr  = 1'b1;
          default: ld_o.bad  = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/picmd_init_fsm.sv
module picmd_init_fsm
  import picmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cw_ld_t   ld_i,
  input  logic     ic4_i,
  input  logic     sngl_i,
  output init_st_e state_o
);
  init_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (ld_i.icw1)      st_d = ST_ICW2;
    else if (ld_i.icw2) st_d = !sngl_i ? ST_ICW3 : (ic4_i ? ST_ICW4 : ST_RDY);
    else if (ld_i.icw3) st_d = ic4_i ? ST_ICW4 : ST_RDY;
    else if (ld_i.icw4) st_d = ST_RDY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_ICW1;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/picmd_regs.sv
module picmd_regs
  import picmd_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cw_ld_t            ld_i,
  input  logic              rd_en_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] irr_i,
  input  logic [DATA_W-1:0] isr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [3:0]        icw1_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic [DATA_W-1:0] cascade_o,
  output logic [3:0]        icw4_o,
  output logic [2:0]        ocw2_cmd_o,
  output logic [LVL_W-1:0]  ocw2_lvl_o,
  output logic              ocw2_stb_o,
  output logic              err_o
);
  logic [DATA_W-1:0] imr_q, rd_d;
  logic [1:0]        rsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icw1_o     <= '0;
      vec_base_o <= '0;
      cascade_o  <= '0;
      icw4_o     <= '0;
      imr_q      <= '0;
      ocw2_cmd_o <= '0;
      ocw2_lvl_o <= '0;
      rsel_q     <= 2'b10;
    end else begin
      if (ld_i.icw1) icw1_o     <= wdata_i[3:0];
      if (ld_i.icw2) vec_base_o <= wdata_i;
      if (ld_i.icw3) cascade_o  <= wdata_i;
      if (ld_i.icw4) icw4_o     <= wdata_i[4:1];
      if (ld_i.imr)  imr_q      <= wdata_i;
      if (ld_i.ocw2) begin
        ocw2_cmd_o <= wdata_i[7:5];
        ocw2_lvl_o <= wdata_i[LVL_W-1:0];
      end
      if (ld_i.ocw3) rsel_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    if (a0_i)                 rd_d = imr_q;
    else if (rsel_q == 2'b10) rd_d = irr_i;
    else if (rsel_q == 2'b11) rd_d = isr_i;
    else                      rd_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      ocw2_stb_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_d;
      ocw2_stb_o <= ld_i.ocw2;
      err_o      <= ld_i.bad;
    end
  end
endmodule

// File: rtl/picmd_seq.sv
module picmd_seq
  import picmd_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] irr_i,
  input  logic [DATA_W-1:0] isr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              single_o,
  output logic              adi_o,
  output logic              level_o,
  output logic [DATA_W-1:0] cascade_o,
  output logic              aeoi_o,
  output logic              ms_o,
  output logic              buf_o,
  output logic              sfnm_o,
  output logic              ocw2_stb_o,
  output logic              ocw2_rot_o,
  output logic              ocw2_sl_o,
  output logic              ocw2_eoi_o,
  output logic [LVL_W-1:0]  ocw2_lvl_o,
  output logic              err_o
);
  cw_ld_t     ld;
  init_st_e   state;
  logic [3:0] icw1, icw4;
  logic [2:0] cmd;

  picmd_decode i_decode (
    .wr_en_i (wr_en_i),
    .a0_i    (a0_i),
    .sel_i   (wdata_i[CW_SEL_BIT]),
    .kind_i  (wdata_i[CW_KIND_BIT]),
    .state_i (state),
    .ld_o    (ld)
  );

  picmd_init_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ld),
    .ic4_i   (icw1[0]),
    .sngl_i  (icw1[1]),
    .state_o (state)
  );

  picmd_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (ld),
    .rd_en_i    (rd_en_i),
    .a0_i       (a0_i),
    .wdata_i    (wdata_i),
    .irr_i      (irr_i),
    .isr_i      (isr_i),
    .rdata_o    (rdata_o),
    .icw1_o     (icw1),
    .vec_base_o (vec_base_o),
    .cascade_o  (cascade_o),
    .icw4_o     (icw4),
    .ocw2_cmd_o (cmd),
    .ocw2_lvl_o (ocw2_lvl_o),
    .ocw2_stb_o (ocw2_stb_o),
    .err_o      (err_o)
  );

  assign ready_o    = (state == ST_RDY);
  assign single_o   = icw1[1];
  assign adi_o      = icw1[2];
  assign level_o    = icw1[3];
  assign aeoi_o     = icw4[0];
  assign ms_o       = icw4[1];
  assign buf_o      = icw4[2];
  assign sfnm_o     = icw4[3];
  assign ocw2_rot_o = cmd[2];
  assign ocw2_sl_o  = cmd[1];
  assign ocw2_eoi_o = cmd[0];
endmodule

// File: rtl/picmd_seq_chk.sv
module picmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              a0_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] vec_base_o,
  input logic              ocw2_stb_o,
  input logic              err_o
);
  logic icw1_wr;
  assign icw1_wr = wr_en_i && !a0_i && wdata_i[4];

  AST_ICW1_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1_wr |=> !ready_o);  // R2
  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !icw1_wr) |=> ready_o);  // R2
  AST_VEC_ONLY_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && a0_i) |=> $stable(vec_base_o));  // R3
  AST_VEC_KEPT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !icw1_wr) |=> $stable(vec_base_o));  // R6
  AST_STB_FROM_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocw2_stb_o |-> $past(wr_en_i && !a0_i && !wdata_i[4] && ready_o));  // R7
  AST_ERR_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i && !ready_o));  // R9
  AST_ERR_NOT_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && ocw2_stb_o));  // R9
endmodule

bind picmd_seq picmd_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .a0_i       (a0_i),
  .wdata_i    (wdata_i),
  .ready_o    (ready_o),
  .vec_base_o (vec_base_o),
  .ocw2_stb_o (ocw2_stb_o),
  .err_o      (err_o)
);

// File: tb/test_picmd_seq.sv
`timescale 1ns/1ps
module test_picmd_seq;
  localparam logic [7:0] IRR_V = 8'hA5;
  localparam logic [7:0] ISR_V = 8'h3C;
  localparam int N_VEC = 14;
  // {is_read, a0, data, expected}
  localparam logic [17:0] VEC [N_VEC] = '{
    {1'b1, 1'b0, 8'h00, 8'hA5},  // R1 reset select returns IRR
    {1'b1, 1'b1, 8'h00, 8'h00},  // R1 mask 0
    {1'b0, 1'b0, 8'h11, 8'h00},  // R2 cascade, fourth byte follows
    {1'b0, 1'b1, 8'h40, 8'h00},  // R3
    {1'b0, 1'b1, 8'h04, 8'h00},  // R4
    {1'b0, 1'b1, 8'h03, 8'h00},  // R5
    {1'b0, 1'b1, 8'h5A, 8'h00},  // R6 mask
    {1'b1, 1'b1, 8'h00, 8'h5A},  // R6
    {1'b0, 1'b0, 8'h0B, 8'h00},  // R8 select ISR
    {1'b1, 1'b0, 8'h00, 8'h3C},  // R8
    {1'b0, 1'b0, 8'h0A, 8'h00},  // R8 select IRR
    {1'b1, 1'b0, 8'h00, 8'hA5},  // R8
    {1'b0, 1'b0, 8'h08, 8'h00},  // R8 select none
    {1'b1, 1'b0, 8'h00, 8'h00}   // R8
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, a0_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] irr_i = IRR_V, isr_i = ISR_V;
  logic [7:0] rdata_o, vec_base_o, cascade_o;
  logic ready_o, single_o, adi_o, level_o, aeoi_o, ms_o, buf_o, sfnm_o;
  logic ocw2_stb_o, ocw2_rot_o, ocw2_sl_o, ocw2_eoi_o, err_o;
  logic [2:0] ocw2_lvl_o;
  int n_chk = 0, n_err = 0;

  always #5 clk_i = ~clk_i;

  picmd_seq i_picmd_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; a0_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; a0_i = a;
    @(negedge clk_i); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic do_reset;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    do_reset();
    chk("R1 ready", ready_o, 0);
    chk("R1 vec_base", vec_base_o, 0);
    chk("R1 cascade", cascade_o, 0);
    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][17]) begin
        rd(VEC[i][16], r);
        chk($sformatf("R6/R8 vec %0d", i), r, VEC[i][7:0]);
      end else wr(VEC[i][16], VEC[i][15:8]);
    end
    chk("R3 vec_base", vec_base_o, 8'h40);
    chk("R4 cascade", cascade_o, 8'h04);
    chk("R5 aeoi", aeoi_o, 1);
    chk("R5 sfnm", sfnm_o, 0);
    chk("R5 ready", ready_o, 1);
    chk("R2 single", single_o, 0);

    // R7 operation command: rot=0 sl=1 eoi=1 lvl=3
    wr(1'b0, 8'h63);
    chk("R7 stb", ocw2_stb_o, 1);
    chk("R7 fields", {ocw2_rot_o, ocw2_sl_o, ocw2_eoi_o, ocw2_lvl_o}, 6'b011_011);
    chk("R7 err", err_o, 0);
    @(negedge clk_i);
    chk("R7 stb one cycle", ocw2_stb_o, 0);

    // R2 restart from ready: single, no fourth byte, level mode, adi
    wr(1'b0, 8'h1E);
    chk("R2 leaves ready", ready_o, 0);
    chk("R2 flags", {level_o, adi_o, single_o}, 3'b111);
    rd(1'b1, r);
    chk("R2 mask kept", r, 8'h5A);
    wr(1'b1, 8'h20);
    chk("R3 single no ic4 ready", ready_o, 1);
    chk("R3 vec_base", vec_base_o, 8'h20);
    chk("R4 cascade untouched", cascade_o, 8'h04);

    // R3/R5 single with fourth byte
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h30);
    chk("R3 single ic4 waits", ready_o, 0);
    wr(1'b1, 8'h1E);
    chk("R5 ready", ready_o, 1);
    chk("R5 fields", {sfnm_o, buf_o, ms_o, aeoi_o}, 4'b1111);
    chk("R4 cascade skipped", cascade_o, 8'h04);

    // R4 cascade without fourth byte
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h50);
    chk("R4 waits third", ready_o, 0);
    wr(1'b1, 8'hFF);
    chk("R4 ready", ready_o, 1);
    chk("R4 cascade", cascade_o, 8'hFF);
    chk("R5 fields kept", aeoi_o, 1);

    // R9 ignored writes
    do_reset();
    wr(1'b1, 8'h77);
    chk("R9 err odd in first", err_o, 1);
    chk("R9 ready", ready_o, 0);
    @(negedge clk_i);
    chk("R9 err one cycle", err_o, 0);
    rd(1'b1, r);
    chk("R9 mask untouched", r, 8'h00);
    chk("R9 vec untouched", vec_base_o, 8'h00);
    wr(1'b0, 8'h11);
    wr(1'b0, 8'h08);
    chk("R9 err even in second", err_o, 1);
    chk("R9 no stb", ocw2_stb_o, 0);
    wr(1'b1, 8'h60);
    chk("R9 still in second", vec_base_o, 8'h60);
    chk("R9 went to third", ready_o, 0);
    rd(1'b0, r);
    chk("R9 select untouched", r, IRR_V);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule